// File: doc/BRIEF.md
# Masked Processor Status Word

This block keeps the 32-bit status word of a processor core. The top four bits hold the condition flags, negative, zero, carry and overflow. The remaining bits hold control state, and the low five bits of those form the processor mode. The read port always shows the stored control bits together with the current flag values.

Software writes arrive with a value and a per-bit mask.

- If the mask selects any flag bit, all four flags are reloaded together from the value.
- The other bits merge bit by bit: each selected bit takes the value's bit, and each unselected bit keeps its old state.
- The ALU and the shifter can also load the four flags directly.
- When a write would change the selected mode bits, the block raises a mode-change request in the same cycle. The request carries the new mode, so the banked-register logic can act before the stored word changes.

Top module: `sw_status_reg`

## Requirements
- R1: After reset, rd_data_o reads 0x00000013. All flags are clear, bits 27..5 are zero, and the mode field (bits 4..0) holds 5'h13.
- R2: Bit 31 of the word is N, bit 30 is Z, bit 29 is C and bit 28 is V. When dp_flag_en_i is high and no software write selects a flag bit, dp_flags_i ({N,Z,C,V}) appears in bits 31..28 from the next cycle.
- R3: A write whose mask has any of bits 31..28 set loads all four flags from wr_data_i[31..28]. This includes flags whose own mask bit is clear.
- R4: On a write, each of bits 27..0 becomes (old AND NOT mask) OR (value AND mask). The flag bits take no part in this merge.
- R5: In a cycle where a software write selects a flag bit, the write sets the flags and dp_flags_i is ignored. A write that selects no flag bit leaves a simultaneous datapath update in effect.
- R6: During a write cycle, mode_req_o is high exactly when (wr_data_i[4:0] XOR current mode) AND wr_mask_i[4:0] is nonzero. While mode_req_o is high, mode_new_o equals the merged mode that the register holds after the edge.
- R7: Without a write and without a datapath update, rd_data_o holds its value.
- R8: No mode request is raised without a write. No request is raised when the selected mode bits already equal the current ones, even if unselected mode bits of the value differ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 32 | Write value |
| wr_mask_i | input | 32 | Per-bit write select |
| dp_flag_en_i | input | 1 | Datapath flag update strobe |
| dp_flags_i | input | 4 | Datapath flags {N,Z,C,V} |
| rd_data_o | output | 32 | Assembled status word |
| mode_req_o | output | 1 | Mode-change request, valid in the write cycle |
| mode_new_o | output | 5 | Mode after the write |

## Verification
The assertions check the following on every cycle:
- the flags and control bits hold when nothing loads them;
- a flag-selecting write wins over the datapath;
- a datapath-only update lands;
- no request is raised without a write;
- a raised request's mode is the one stored afterwards.

The bench's scenarios are needed for the reset value, the bit-exact merge of the control bits, and the group reload of flags from a single mask bit. They also cover requests suppressed when only unselected mode bits differ.

// File: rtl/sw_status_pkg.sv
package sw_status_pkg;
  localparam int unsigned FLAG_W = 4;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/sw_flag_unit.sv
module sw_flag_unit
  import sw_status_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  logic  wr_sel_i,
  input  nzcv_t wr_flags_i,
  input  logic  dp_en_i,
  input  nzcv_t dp_flags_i,
  output nzcv_t flags_o
);
  nzcv_t flags_q;
  logic  sw_load;

  assign sw_load = wr_en_i & wr_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flags_q <= '0;
    else if (sw_load)  flags_q <= wr_flags_i;   // software wins
    else if (dp_en_i)  flags_q <= dp_flags_i;
  end

  assign flags_o = flags_q;

  p_sw_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i) |=> flags_o == $past(wr_flags_i));

  p_dp_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_en_i && wr_sel_i) && dp_en_i) |=> flags_o == $past(dp_flags_i));

  p_flags_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !dp_en_i) |=> $stable(flags_o));
endmodule

// File: rtl/sw_ctrl_field.sv
module sw_ctrl_field #(
  parameter int unsigned CTRL_W   = 28,
  parameter int unsigned MODE_W   = 5,
  parameter logic [MODE_W-1:0] RST_MODE = 5'h13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic [CTRL_W-1:0] wr_mask_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              mode_req_o,
  output logic [MODE_W-1:0] mode_new_o
);
  localparam logic [CTRL_W-1:0] RST_WORD = CTRL_W'(RST_MODE);

  logic [CTRL_W-1:0] ctrl_q;
  logic [CTRL_W-1:0] ctrl_d;
  logic [MODE_W-1:0] mode_diff;

  // Per-bit merge, one slice per bit
  for (genvar b = 0; b < CTRL_W; b++) begin : g_merge
    assign ctrl_d[b] = wr_mask_i[b] ? wr_data_i[b] : ctrl_q[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= RST_WORD;
    else if (wr_en_i) ctrl_q <= ctrl_d;
  end

  assign mode_diff  = (wr_data_i[MODE_W-1:0] ^ ctrl_q[MODE_W-1:0]) & wr_mask_i[MODE_W-1:0];
  assign mode_req_o = wr_en_i & (|mode_diff);
  assign mode_new_o = ctrl_d[MODE_W-1:0];
  assign ctrl_o     = ctrl_q;

  p_req_mode_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_req_o |=> ctrl_o[MODE_W-1:0] == $past(mode_new_o));

  p_no_req_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |-> !mode_req_o);

  p_ctrl_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ctrl_o));
endmodule

// File: rtl/sw_status_reg.sv
module sw_status_reg
  import sw_status_pkg::*;
#(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned MODE_W   = 5,
  parameter logic [MODE_W-1:0] RST_MODE = 5'h13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [WORD_W-1:0] wr_mask_i,
  input  logic              dp_flag_en_i,
  input  logic [FLAG_W-1:0] dp_flags_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              mode_req_o,
  output logic [MODE_W-1:0] mode_new_o
);
  localparam int unsigned CTRL_W = WORD_W - FLAG_W;

  nzcv_t             flags;
  logic [CTRL_W-1:0] ctrl;
  logic              flag_sel;

  assign flag_sel = |wr_mask_i[WORD_W-1:CTRL_W];

  sw_flag_unit u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (flag_sel),
    .wr_flags_i (nzcv_t'(wr_data_i[WORD_W-1:CTRL_W])),
    .dp_en_i    (dp_flag_en_i),
    .dp_flags_i (nzcv_t'(dp_flags_i)),
    .flags_o    (flags)
  );

  sw_ctrl_field #(
    .CTRL_W   (CTRL_W),
    .MODE_W   (MODE_W),
    .RST_MODE (RST_MODE)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i[CTRL_W-1:0]),
    .wr_mask_i  (wr_mask_i[CTRL_W-1:0]),
    .ctrl_o     (ctrl),
    .mode_req_o (mode_req_o),
    .mode_new_o (mode_new_o)
  );

  assign rd_data_o = {flags, ctrl};

  p_flag_group_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && flag_sel) |=> rd_data_o[WORD_W-1:CTRL_W] == $past(wr_data_i[WORD_W-1:CTRL_W]));
endmodule

// File: tb/sim_sw_status_reg.sv
module sim_sw_status_reg;
  localparam int unsigned CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] wr_mask = '0;
  logic        dp_en = 1'b0;
  logic [3:0]  dp_flags = '0;
  logic [31:0] rd_data;
  logic        mode_req;
  logic [4:0]  mode_new;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [3:0]  m_flags;
  logic [27:0] m_ctrl;

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_status_reg u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wr_mask_i(wr_mask), .dp_flag_en_i(dp_en), .dp_flags_i(dp_flags),
    .rd_data_o(rd_data), .mode_req_o(mode_req), .mode_new_o(mode_new)
  );

  function automatic logic [27:0] f_merge(logic [27:0] c, logic [27:0] d, logic [27:0] m);
    return (c & ~m) | (d & m);
  endfunction

  function automatic logic f_req(logic we, logic [4:0] cur, logic [4:0] d, logic [4:0] m);
    return we && (((cur ^ d) & m) != 5'd0);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive after negedge, check request, clock, check word
  task automatic step(logic we, logic [31:0] d, logic [31:0] m, logic de, logic [3:0] df,
                      string tag_req, string tag_word);
    logic r;
    logic [27:0] nc;
    @(negedge clk);
    wr_en = we; wr_data = d; wr_mask = m; dp_en = de; dp_flags = df;
    #1;
    r  = f_req(we, m_ctrl[4:0], d[4:0], m[4:0]);
    nc = we ? f_merge(m_ctrl, d[27:0], m[27:0]) : m_ctrl;
    check({tag_req, " req"}, {31'd0, mode_req}, {31'd0, r});
    if (r) check({tag_req, " mode"}, {27'd0, mode_new}, {27'd0, nc[4:0]});
    @(posedge clk);
    if (we && (m[31:28] != 4'd0)) m_flags = d[31:28];
    else if (de) m_flags = df;
    m_ctrl = nc;
    #1;
    check(tag_word, rd_data, {m_flags, m_ctrl});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0013));
    m_flags = 4'd0; m_ctrl = 28'h13;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset word", rd_data, 32'h0000_0013);
    check("R1 reset req", {31'd0, mode_req}, 32'd0);

    step(1'b1, 32'hA5A5_A5B0, 32'hFFFF_FFFF, 1'b0, 4'h0, "R6", "R4 full write");
    step(1'b1, 32'h5000_0000, 32'h1000_0000, 1'b0, 4'h0, "R8", "R3 single mask bit");
    step(1'b0, 32'h0, 32'h0, 1'b1, 4'hC, "R8", "R2 datapath flags");
    step(1'b1, 32'h0000_0000, 32'h8000_0000, 1'b1, 4'hF, "R8", "R5 sw beats dp");
    step(1'b1, 32'hFFFF_3300, 32'h0000_FF00, 1'b1, 4'h3, "R8", "R5 dp with non-flag write");
    step(1'b1, 32'h0000_0010, 32'h0000_001F, 1'b0, 4'h0, "R8 same mode", "R4 same mode");
    step(1'b1, 32'h0000_001F, 32'h0000_0010, 1'b0, 4'h0, "R8 unselected differ", "R4 partial");
    step(1'b1, 32'h0000_0003, 32'h0000_0003, 1'b0, 4'h0, "R6 partial change", "R4 mode bits");
    step(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 4'h0, "R8 no write", "R7 hold");
    step(1'b0, 32'h0, 32'h0, 1'b0, 4'h0, "R8", "R7 hold again");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] d, m;
      d = $urandom();
      m = $urandom();
      if ((i % 4) == 0) m[31:28] = 4'd0;
      if ((i % 5) == 0) m[4:0] = 5'd0;
      step(($urandom() % 4) != 0, d, m, ($urandom() % 2) == 1, 4'($urandom()),
           "R6", "R4 random");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule